// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

This block moves the bits of an N-bit word by a variable distance. A 3-bit operation code picks one of six treatments: a logical shift in either direction, an arithmetic shift in either direction, or a rotation in either direction. The two leftover codes return the word as it came in. The word width is a parameter with a default of 6. The amount input is just wide enough to hold the value N.

The datapath is combinational. A parameter selects whether the result goes through one output register or straight to the output. The register clears asynchronously on an active-low reset.

The two arithmetic shifts differ in their fill bit. A right shift fills the vacated high bits with copies of the old top bit, so the sign is kept. A left shift fills the vacated low bits with copies of the old bottom bit instead of zeros.

Shifts whose amount reaches or exceeds the width saturate. Logical shifts then give all zeros, and arithmetic shifts give the fill bit in every position. Rotations take the amount modulo N. The unit is used wherever a datapath needs one shared shifter for several instruction-like operations.

Top module: `shift_rotate_unit`

## Requirements
- R1: The operation code op_i selects the operation. Codes 3'b110 and 3'b111 return data_i unchanged.
- R2: Code 3'b000 is a logical left shift that fills the vacated low bits with 0. For N=6, 010011 shifted by 2 gives 001100.
- R3: Code 3'b001 is a logical right shift that fills the vacated high bits with 0. For N=6, 010011 shifted by 2 gives 000100.
- R4: Code 3'b010 is an arithmetic left shift. The vacated low bits take the value of data_i[0]. For N=6, 010011 shifted by 2 gives 001111.
- R5: Code 3'b011 is an arithmetic right shift. The vacated high bits take the value of data_i[N-1].
- R6: Code 3'b100 rotates left, so bits leaving the top re-enter at the bottom. For N=6, 010011 rotated by 2 gives 001101.
- R7: Code 3'b101 rotates right, so bits leaving the bottom re-enter at the top. For N=6, 010011 rotated by 2 gives 110100.
- R8: An amount of zero returns data_i unchanged for every operation code.
- R9: For shift amounts of N or more, logical shifts return all zeros. The arithmetic left shift returns data_i[0] in every bit, and the arithmetic right shift returns data_i[N-1] in every bit.
- R10: Rotations use the amount modulo N, so rotating by N+k gives the same result as rotating by k.
- R11: With REG_OUT=1 (the default), data_o shows the result for the inputs present at a rising clk_i edge, starting just after that edge. While rst_ni is low, data_o is 0.
- R12: The width N is a parameter, and amt_i is $clog2(N+1) bits wide. R1 to R11 hold for both N=6 and N=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | N | Word to be shifted or rotated |
| op_i | input | 3 | Operation code |
| amt_i | input | $clog2(N+1) | Unsigned shift or rotate distance |
| data_o | output | N | Result word |

## Verification
The assertions check several properties on every cycle. The unused codes and a zero amount must reproduce the previous input. Saturated shifts must give a uniform fill. The edge bit of every shift must equal its fill bit, and a rotation must keep the number of ones. These checks cannot tell a correct rotation or a correct mid-range shift from a wrong one with the same fill or bit count. That needs the bench's reference model. For N=6 the bench compares every data, code and amount combination, and for N=8 it compares every code and amount over random data.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [2:0] {
    OP_LSL   = 3'b000,
    OP_LSR   = 3'b001,
    OP_ASL   = 3'b010,
    OP_ASR   = 3'b011,
    OP_ROL   = 3'b100,
    OP_ROR   = 3'b101,
    OP_PASS0 = 3'b110,
    OP_PASS1 = 3'b111
  } shu_op_e;

endpackage

// File: rtl/shu_reverse.sv
module shu_reverse #(
  parameter int N = 6
) (
  input  logic [N-1:0] din_i,
  output logic [N-1:0] dout_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign dout_o[b] = din_i[N-1-b];
  end

endmodule

// File: rtl/shu_barrel.sv
// Saturating right shifter: one stage per amount bit, vacated bits take fill_i.
module shu_barrel #(
  parameter int N  = 6,
  parameter int AW = $clog2(N+1)
) (
  input  logic [N-1:0]  din_i,
  input  logic          fill_i,
  input  logic [AW-1:0] amt_i,
  output logic [N-1:0]  dout_o
);

  logic [N-1:0] stg [AW+1];

  assign stg[0] = din_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    if (SH >= N) begin : g_full
      assign stg[s+1] = amt_i[s] ? {N{fill_i}} : stg[s];
    end else begin : g_part
      assign stg[s+1] = amt_i[s] ? {{SH{fill_i}}, stg[s][N-1:SH]} : stg[s];
    end
  end

  assign dout_o = stg[AW];

endmodule

// File: rtl/shu_rotate.sv
// Right rotator; a left rotation by r becomes a right rotation by N-r.
module shu_rotate #(
  parameter int N  = 6,
  parameter int AW = $clog2(N+1)
) (
  input  logic [N-1:0]  din_i,
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  output logic [N-1:0]  dout_o
);

  localparam logic [AW-1:0] N_W = AW'(N);

  logic [AW-1:0] amt_mod;
  logic [AW-1:0] amt_eff;
  logic [N-1:0]  stg [AW+1];

  // amt_i < 2N, so one conditional subtract gives the remainder
  assign amt_mod = (amt_i >= N_W) ? amt_i - N_W : amt_i;

  always_comb begin
    if (!left_i)            amt_eff = amt_mod;
    else if (amt_mod == '0) amt_eff = '0;
    else                    amt_eff = N_W - amt_mod;
  end

  assign stg[0] = din_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SHM = (1 << s) % N;
    if (SHM == 0) begin : g_id
      assign stg[s+1] = stg[s];
    end else begin : g_rot
      assign stg[s+1] = amt_eff[s] ? {stg[s][SHM-1:0], stg[s][N-1:SHM]} : stg[s];
    end
  end

  assign dout_o = stg[AW];

endmodule

// File: rtl/shu_outreg.sv
module shu_outreg #(
  parameter int N       = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shu_pkg::*;
#(
  parameter int N       = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int AW     = $clog2(N+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  data_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] amt_i,
  output logic [N-1:0]  data_o
);

  shu_op_e      op;
  logic         is_left;
  logic         fill;
  logic [N-1:0] data_rev;
  logic [N-1:0] shift_src;
  logic [N-1:0] shift_raw;
  logic [N-1:0] shift_raw_rev;
  logic [N-1:0] shift_res;
  logic [N-1:0] rot_res;
  logic [N-1:0] result;

  assign op      = shu_op_e'(op_i);
  assign is_left = (op == OP_LSL) || (op == OP_ASL);

  always_comb begin
    case (op)
      OP_ASL:  fill = data_i[0];
      OP_ASR:  fill = data_i[N-1];
      default: fill = 1'b0;
    endcase
  end

  // left shifts reuse the right shifter between two bit reversals
  shu_reverse #(.N(N)) u_rev_in (
    .din_i  (data_i),
    .dout_o (data_rev)
  );

  assign shift_src = is_left ? data_rev : data_i;

  shu_barrel #(.N(N), .AW(AW)) u_barrel (
    .din_i  (shift_src),
    .fill_i (fill),
    .amt_i  (amt_i),
    .dout_o (shift_raw)
  );

  shu_reverse #(.N(N)) u_rev_out (
    .din_i  (shift_raw),
    .dout_o (shift_raw_rev)
  );

  assign shift_res = is_left ? shift_raw_rev : shift_raw;

  shu_rotate #(.N(N), .AW(AW)) u_rotate (
    .din_i  (data_i),
    .amt_i  (amt_i),
    .left_i (op == OP_ROL),
    .dout_o (rot_res)
  );

  always_comb begin
    case (op)
      OP_LSL, OP_LSR, OP_ASL, OP_ASR: result = shift_res;
      OP_ROL, OP_ROR:                 result = rot_res;
      default:                        result = data_i;
    endcase
  end

  shu_outreg #(.N(N), .REG_OUT(REG_OUT)) u_outreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (result),
    .q_o    (data_o)
  );

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int N       = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int AW     = $clog2(N+1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  data_i,
  input logic [2:0]    op_i,
  input logic [AW-1:0] amt_i,
  input logic [N-1:0]  data_o
);

  localparam logic [AW-1:0] N_W = AW'(N);

  if (REG_OUT) begin : g_seq
    // R11
    always @(negedge clk_i) begin
      if (!rst_ni) begin
        reset_clear_chk: assert (data_o == '0);
      end
    end

    // R1
    passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[2:1] == 2'b11) |=> data_o == $past(data_i));

    // R8
    zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (amt_i == '0) |=> data_o == $past(data_i));

    // R9
    logic_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[2:1] == 2'b00 && amt_i >= N_W) |=> data_o == '0);

    // R9
    asl_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b010 && amt_i >= N_W) |=> data_o == {N{$past(data_i[0])}});

    // R9
    asr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b011 && amt_i >= N_W) |=> data_o == {N{$past(data_i[N-1])}});

    // R2
    lsl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b000 && amt_i != '0) |=> data_o[0] == 1'b0);

    // R3
    lsr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b001 && amt_i != '0) |=> data_o[N-1] == 1'b0);

    // R4
    asl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b010) |=> data_o[0] == $past(data_i[0]));

    // R5
    asr_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'b011) |=> data_o[N-1] == $past(data_i[N-1]));

    // R6, R7, R10
    rot_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[2:1] == 2'b10) |=> $countones(data_o) == $countones($past(data_i)));
  end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .op_i   (op_i),
  .amt_i  (amt_i),
  .data_o (data_o)
);

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;

  localparam int A6 = $clog2(6+1);
  localparam int A8 = $clog2(8+1);

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [5:0]    d6 = '0;
  logic [2:0]    op6 = '0;
  logic [A6-1:0] a6 = '0;
  logic [5:0]    q6;
  logic [7:0]    d8 = '0;
  logic [2:0]    op8 = '0;
  logic [A8-1:0] a8 = '0;
  logic [7:0]    q8;

  item_t sb6[$];
  item_t sb8[$];
  int n_vec = 0;
  int n_bad = 0;

  shift_rotate_unit #(.N(6)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (d6), .op_i (op6), .amt_i (a6), .data_o (q6)
  );

  shift_rotate_unit #(.N(8)) uut_w8 (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (d8), .op_i (op8), .amt_i (a8), .data_o (q8)
  );

  function automatic logic [7:0] ref_op(int n, logic [7:0] d, int op, int k);
    logic [7:0] r;
    int rr;
    r  = '0;
    rr = k % n;
    for (int i = 0; i < n; i++) begin
      case (op)
        0: r[i] = (i - k >= 0) ? d[i-k] : 1'b0;
        1: r[i] = (i + k < n)  ? d[i+k] : 1'b0;
        2: r[i] = (i - k >= 0) ? d[i-k] : d[0];
        3: r[i] = (i + k < n)  ? d[i+k] : d[n-1];
        4: r[i] = d[(i - rr + n) % n];
        5: r[i] = d[(i + rr) % n];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(int n, int op, int k);
    if (k == 0) return "R8";
    if (op >= 6) return "R1";
    if (op >= 4 && k >= n) return "R10";
    if (op < 4 && k >= n) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive6(logic [5:0] d, int op, int k);
    item_t it;
    @(negedge clk);
    d6  = d;
    op6 = op[2:0];
    a6  = k[A6-1:0];
    it.exp = ref_op(6, {2'b00, d}, op, k);
    it.tag = tag_of(6, op, k);
    sb6.push_back(it);
  endtask

  task automatic drive8(logic [7:0] d, int op, int k);
    item_t it;
    @(negedge clk);
    d8  = d;
    op8 = op[2:0];
    a8  = k[A8-1:0];
    it.exp = ref_op(8, d, op, k);
    it.tag = {tag_of(8, op, k), "/R12"};
    sb8.push_back(it);
  endtask

  // monitor: every result appears one edge after its inputs (R11)
  always @(posedge clk) begin
    item_t m6;
    item_t m8;
    #2;
    if (sb6.size() > 0) begin
      m6 = sb6.pop_front();
      n_vec++;
      if (q6 !== m6.exp[5:0]) begin
        n_bad++;
        $display("FAIL %s N=6: actual %b expected %b", m6.tag, q6, m6.exp[5:0]);
      end
    end
    if (sb8.size() > 0) begin
      m8 = sb8.pop_front();
      n_vec++;
      if (q8 !== m8.exp) begin
        n_bad++;
        $display("FAIL %s N=8: actual %b expected %b", m8.tag, q8, m8.exp);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    d6 = 6'b111111; op6 = 3'b110; d8 = 8'hff; op8 = 3'b111;
    repeat (3) @(negedge clk);
    // R11: output held at zero during reset despite active inputs
    n_vec += 2;
    if (q6 !== 6'b0) begin
      n_bad++;
      $display("FAIL R11 reset N=6: actual %b expected 000000", q6);
    end
    if (q8 !== 8'b0) begin
      n_bad++;
      $display("FAIL R11 reset N=8: actual %b expected 00000000", q8);
    end
    rst_ni = 1'b1;

    // worked examples: R2 R3 R4 R6 R7
    drive6(6'b010011, 0, 2);
    drive6(6'b010011, 1, 2);
    drive6(6'b010011, 2, 2);
    drive6(6'b010011, 4, 2);
    drive6(6'b010011, 5, 2);
    // R5 sign kept, R9 saturation, R10 modulo
    drive6(6'b100110, 3, 2);
    drive6(6'b101101, 0, 6);
    drive6(6'b101100, 2, 7);
    drive6(6'b100000, 3, 6);
    drive6(6'b010011, 4, 7);
    drive6(6'b010011, 5, 6);
    // R1 R8
    drive6(6'b011010, 6, 3);
    drive6(6'b011010, 7, 5);
    drive6(6'b110001, 3, 0);

    // exhaustive N=6
    for (int d = 0; d < 64; d++)
      for (int op = 0; op < 8; op++)
        for (int k = 0; k < 8; k++)
          drive6(d[5:0], op, k);

    // R12: N=8, all codes and amounts with edge and random data
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 16; k++) begin
        drive8(8'h80, op, k);
        drive8(8'h01, op, k);
        for (int r = 0; r < 18; r++) drive8($urandom() & 8'hff, op, k);
      end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule